// File: doc/BRIEF.md
# Paced Sample Playout Buffer with PWM Output

This block sits between an audio sample producer and a single-wire pulse-width output used as a low-cost DAC. The producer pushes 8-bit samples into a 32-entry circular buffer whenever the block reports room. A free-running divider produces a one-cycle sample tick every `PRESCALE * CONV_CYCLES` clocks. On each tick the oldest held sample, if there is one, becomes the new PWM duty value. The producer can therefore compute samples ahead of time in bursts while the output stays locked to a steady sample rate.

The PWM counter is meant to run four times faster than the system clock. The block keeps a single clock domain. Each system cycle it presents the four consecutive PWM sub-steps as a lane vector, lane 0 first, ready for a 4:1 serializer running at the fast clock. In each PWM period the output is set when the counter wraps and cleared when the counter reaches the duty value. It is therefore high while the counter position is below the duty.

Top module: `sample_pacer_dac`

## Requirements
- R1: After reset the buffer level is 0, the empty flag is 1, the almost-full flag is 0, the write-ready flag is 1 and the duty value is 128.
- R2: A write is taken only in a cycle in which fewer than 31 entries are held. `wr_ready_o` is high exactly when the level is below 31, and the level never exceeds 31.
- R3: Samples reach the duty register in the order they were written. Read and write positions wrap modulo 32, so the order holds across any number of writes.
- R4: `sample_tick_o` is a one-cycle pulse. It is high in the last cycle of each window of `PRESCALE*CONV_CYCLES` clocks counted from reset release, so the default is every 1664 cycles.
- R5: At a tick with a non-zero level, the oldest sample loads into the duty register on the following edge and the level drops by one, unless a write is taken in the same cycle.
- R6: At a tick with an empty buffer, the duty value stays as it was.
- R7: When a write is taken in the same cycle as a tick read, the level is unchanged.
- R8: A PWM phase counter starts at 0 on reset release and advances by one each cycle, modulo 256/4. Lane i of `pwm_lanes_o` is 1 exactly when phase*4 + i is below the duty value. Duty 0 gives all lanes low.
- R9: `fifo_empty_o` is 1 exactly when the level is 0. `fifo_almost_full_o` is 1 exactly when the level is 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Producer offers a sample |
| wr_data_i | input | 8 | Sample value |
| wr_ready_o | output | 1 | Room for a write this cycle |
| fifo_level_o | output | 6 | Entries currently held |
| fifo_empty_o | output | 1 | No entries held |
| fifo_almost_full_o | output | 1 | Level at 31, writes refused |
| sample_tick_o | output | 1 | Sample-rate pulse |
| duty_o | output | 8 | Current PWM compare value |
| pwm_lanes_o | output | 4 | Four PWM sub-steps for this cycle, lane 0 earliest |

## Verification
The bench pushes a 40-sample burst so that writes keep arriving after the level reaches 31. A design that admitted a 32nd entry would show a level of 32 or would drop an old sample from the played order. The buffer is drained through many empty ticks: a design that zeroed or reloaded the duty on an empty tick would show a duty change there. Continuous writes start from an empty buffer, so a tick lands mid-fill. A design that did not net a simultaneous push and pop would drift its level by one. Over 100 samples pass through, which wraps both positions several times, and the lane vector is compared every cycle at duty values including the reset value and 0.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // Clocks between two sample ticks.
  function automatic int unsigned tick_period(input int unsigned prescale,
                                              input int unsigned conv_cycles);
    return prescale * conv_cycles;
  endfunction

  // Position of one PWM sub-step within the full PWM period.
  function automatic int unsigned lane_position(input int unsigned phase,
                                                input int unsigned lane,
                                                input int unsigned lanes);
    return phase * lanes + lane;
  endfunction

  // Writes stop one entry short of the buffer size.
  function automatic logic ring_has_room(input int unsigned level,
                                         input int unsigned depth);
    return level < (depth - 1);
  endfunction

endpackage

// File: rtl/spd_tick_gen.sv
module spd_tick_gen #(
  parameter int unsigned PERIOD = 1664
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap_w;

  assign wrap_w = (cnt_q == LAST);
  assign tick_o = wrap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_w) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PERIOD > 1) begin : g_gap
      p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
      p_tick_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
    end
  endgenerate

endmodule

// File: rtl/spd_ring_fifo.sv
module spd_ring_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req_i,
  input  logic [DATA_W-1:0]          push_data_i,
  input  logic                       pop_req_i,
  output logic                       push_ready_o,
  output logic [DATA_W-1:0]          head_data_o,
  output logic                       pop_fire_o,
  output logic [$clog2(DEPTH):0]     level_o,
  output logic                       empty_o,
  output logic                       almost_full_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_CAP  = LVL_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q;
  logic              room_w, push_fire_w, pop_fire_w;

  assign room_w      = spd_pkg::ring_has_room(32'(level_q), DEPTH);
  assign push_fire_w = push_req_i & room_w;
  assign pop_fire_w  = pop_req_i & (level_q != '0);

  assign push_ready_o  = room_w;
  assign head_data_o   = mem_q[rd_ptr_q];
  assign pop_fire_o    = pop_fire_w;
  assign level_o       = level_q;
  assign empty_o       = (level_q == '0);
  assign almost_full_o = !room_w;

  always_ff @(posedge clk) begin
    if (push_fire_w) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_fire_w) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_fire_w)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_fire_w, pop_fire_w})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_CAP);
  p_refuse_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full_o |=> level_q <= $past(level_q));
  p_pop_decrements_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire_w && !push_fire_w) |=> level_q == $past(level_q) - 1'b1);
  p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire_w && push_fire_w) |=> level_q == $past(level_q));

endmodule

// File: rtl/spd_pwm_gen.sv
module spd_pwm_gen #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned LANES      = 4,
  parameter int unsigned RESET_DUTY = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] duty_o,
  output logic [LANES-1:0]  lanes_o
);
  localparam int unsigned LANE_BITS = $clog2(LANES);
  localparam int unsigned PH_W      = DATA_W - LANE_BITS;

  logic [PH_W-1:0]   phase_q;
  logic [DATA_W-1:0] duty_q;
  logic [DATA_W-1:0] lane_pos_w [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      duty_q  <= DATA_W'(RESET_DUTY);
    end else begin
      phase_q <= phase_q + 1'b1;
      if (load_i) duty_q <= load_data_i;
    end
  end

  assign duty_o = duty_q;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_pos_w[g] = DATA_W'(spd_pkg::lane_position(32'(phase_q), g, LANES));
      // High from counter wrap until the compare match.
      assign lanes_o[g] = lane_pos_w[g] < duty_q;
      if (g > 0) begin : g_order
        p_lane_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
          lanes_o[g] |-> lanes_o[g-1]);
      end
    end
  endgenerate

  p_wrap_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == '0 && duty_q != '0) |-> lanes_o[0]);
  p_zero_duty_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> (lanes_o == '0));
  p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> duty_q == $past(duty_q));

endmodule

// File: rtl/sample_pacer_dac.sv
module sample_pacer_dac #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DEPTH       = 32,
  parameter int unsigned PRESCALE    = 128,
  parameter int unsigned CONV_CYCLES = 13,
  parameter int unsigned PWM_LANES   = 4,
  parameter int unsigned RESET_DUTY  = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic                   wr_ready_o,
  output logic [$clog2(DEPTH):0] fifo_level_o,
  output logic                   fifo_empty_o,
  output logic                   fifo_almost_full_o,
  output logic                   sample_tick_o,
  output logic [DATA_W-1:0]      duty_o,
  output logic [PWM_LANES-1:0]   pwm_lanes_o
);
  localparam int unsigned PERIOD = spd_pkg::tick_period(PRESCALE, CONV_CYCLES);

  logic              tick_w;
  logic              pop_fire_w;
  logic [DATA_W-1:0] head_w;

  spd_tick_gen #(.PERIOD(PERIOD)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  spd_ring_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_req_i    (wr_valid_i),
    .push_data_i   (wr_data_i),
    .pop_req_i     (tick_w),
    .push_ready_o  (wr_ready_o),
    .head_data_o   (head_w),
    .pop_fire_o    (pop_fire_w),
    .level_o       (fifo_level_o),
    .empty_o       (fifo_empty_o),
    .almost_full_o (fifo_almost_full_o)
  );

  spd_pwm_gen #(.DATA_W(DATA_W), .LANES(PWM_LANES), .RESET_DUTY(RESET_DUTY)) u_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (pop_fire_w),
    .load_data_i (head_w),
    .duty_o      (duty_o),
    .lanes_o     (pwm_lanes_o)
  );

  assign sample_tick_o = tick_w;

  p_empty_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick_o && fifo_empty_o) |=> duty_o == $past(duty_o));
  p_tick_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick_o && !fifo_empty_o) |=> duty_o == $past(head_w));
  p_flags_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty_o && fifo_almost_full_o));

endmodule

// File: tb/sample_pacer_dac_tb.sv
module sample_pacer_dac_tb_top;
  localparam int T_DEPTH  = 32;
  localparam int T_PRE    = 2;
  localparam int T_CONV   = 13;
  localparam int T_PERIOD = T_PRE * T_CONV;
  localparam int T_LANES  = 4;
  localparam int T_PHASES = 256 / T_LANES;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       wr_ready, f_empty, f_af, tick;
  logic [5:0] level;
  logic [7:0] duty;
  logic [3:0] lanes;

  always #4 clk = ~clk;

  sample_pacer_dac #(.PRESCALE(T_PRE), .CONV_CYCLES(T_CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(wr_ready), .fifo_level_o(level), .fifo_empty_o(f_empty),
    .fifo_almost_full_o(f_af), .sample_tick_o(tick), .duty_o(duty),
    .pwm_lanes_o(lanes)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference
  int  m_tcnt = 0, m_phase = 0, m_duty = 128;
  int  q[$];
  bit  m_both = 0, m_empty_tick = 0;
  int  m_prev_level = 0, m_prev_duty = 128;
  int  n_both = 0, n_empty_tick = 0, n_refused = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tcnt = 0; m_phase = 0; m_duty = 128; q.delete();
      m_both = 0; m_empty_tick = 0;
    end else begin
      bit t, acc, pop;
      t   = (m_tcnt == T_PERIOD - 1);
      acc = wr_valid && (q.size() < T_DEPTH - 1);
      pop = t && (q.size() > 0);
      if (wr_valid && !acc) n_refused++;
      m_prev_level = q.size();
      m_prev_duty  = m_duty;
      m_both       = acc && pop;
      m_empty_tick = t && (q.size() == 0);
      if (m_both) n_both++;
      if (m_empty_tick) n_empty_tick++;
      if (pop) m_duty = q.pop_front();
      if (acc) q.push_back(int'(wr_data));
      m_tcnt  = t ? 0 : m_tcnt + 1;
      m_phase = (m_phase + 1) % T_PHASES;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int  lv;
    logic [3:0] exp_l;
    lv = q.size();
    for (int i = 0; i < T_LANES; i++) exp_l[i] = ((m_phase * T_LANES + i) < m_duty);
    check(wr_ready == (lv < T_DEPTH - 1), "R2 wr_ready", wr_ready, lv < T_DEPTH - 1);
    check(int'(level) == lv, "R5 level", level, lv);
    check(f_empty == (lv == 0), "R9 empty", f_empty, lv == 0);
    check(f_af == (lv == T_DEPTH - 1), "R9 almost_full", f_af, lv == T_DEPTH - 1);
    check(tick == (m_tcnt == T_PERIOD - 1), "R4 tick", tick, m_tcnt == T_PERIOD - 1);
    check(int'(duty) == m_duty, "R3 duty order", duty, m_duty);
    check(lanes == exp_l, "R8 lanes", lanes, exp_l);
    if (m_both) check(int'(level) == m_prev_level, "R7 level held", level, m_prev_level);
    if (m_empty_tick) check(int'(duty) == m_prev_duty, "R6 duty held", duty, m_prev_duty);
    m_both = 0;
    m_empty_tick = 0;
  endtask

  task automatic step(input bit v, input logic [7:0] d);
    @(negedge clk);
    compare_all();
    wr_valid = v;
    wr_data  = d;
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(level == 0, "R1 level", level, 0);
    check(f_empty == 1'b1, "R1 empty", f_empty, 1);
    check(f_af == 1'b0, "R1 almost_full", f_af, 0);
    check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    check(duty == 8'd128, "R1 duty", duty, 128);
    rst_n = 1'b1;
    // R2: burst longer than the buffer
    for (int i = 0; i < 40; i++) step(1'b1, 8'(i * 7 + 3));
    step(1'b0, 8'h00);
    // Drain through many ticks, then idle on empty ticks (R6)
    for (int i = 0; i < 31 * T_PERIOD + 120; i++) step(1'b0, 8'h00);
    // Set duty to 0 via one sample (R8 corner)
    step(1'b1, 8'h00);
    for (int i = 0; i < 2 * T_PERIOD; i++) step(1'b0, 8'h00);
    // Continuous writes from empty: tick lands mid-fill (R7)
    for (int i = 0; i < 70; i++) step(1'b1, 8'(255 - i * 3));
    // Sparse pseudo-random producer
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[4:0] == 5'd0 || lfsr[9:8] == 2'b11, lfsr[7:0]);
    end
    for (int i = 0; i < 40 * T_PERIOD; i++) step(1'b0, 8'h00);
    check(n_both > 0, "R7 coverage", n_both, 1);
    check(n_empty_tick > 0, "R6 coverage", n_empty_tick, 1);
    check(n_refused > 0, "R2 coverage", n_refused, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule